// File: doc/BRIEF.md
# Triggered Dual-Frame Sample Capture

This block records a stream of digitised sensor samples into a circular store that holds two whole frames. A `start` pulse, issued together with the sensor reset, clears the store pointer and opens the input stream; samples are then written one per accepted transfer at consecutive addresses, wrapping at twice the frame length. The goal is to keep the frame just before a particle arrives and the frame just after it, so that the two can be subtracted pixel by pixel.

In triggered mode the trigger input is accepted only once a first complete frame has been written. From the first accepted trigger, exactly one further frame of samples is written and capture stops. Any later trigger is ignored until the next `start`. In untriggered mode the trigger plays no part, and capture stops as soon as the second frame is complete. When capture stops, `done` rises and the next write address is held on `stop_ptr`. That address holds the oldest stored sample, so reading upward from it modulo the store depth returns both frames in the order they were taken. Reads are served only while `done` is high.

The input is a valid/ready stream. A sample is taken only in a cycle where both `s_valid` and `s_ready` are high. The source must hold `s_data` steady until that happens. `s_ready` is low before the first `start` and after capture stops, so a held sample simply waits. The frame length `FRAME_LEN` is a parameter: a 64x64 sensor uses 4096, and the default is 1024.

Top module: `dual_frame_capture`

## Requirements
- R1: After reset, `done`, `s_ready` and `rd_valid` are all low.
- R2: In the cycle after a `start` pulse, `s_ready` is high and `done` is low. A `start` during a capture aborts it and restarts writing at address 0, with the mode taken from `trig_mode` (1 = triggered, 0 = untriggered) in the `start` cycle.
- R3: Each accepted sample (`s_valid` and `s_ready` high at a clock edge) is written to the next address, starting at 0 and wrapping from 2*FRAME_LEN-1 to 0. Cycles with `s_valid` low write nothing.
- R4: In untriggered mode, capture stops after exactly 2*FRAME_LEN accepted samples, and `stop_ptr` then reads 0.
- R5: In triggered mode, trigger rising edges that arrive before FRAME_LEN samples have been accepted are ignored.
- R6: After an accepted trigger, exactly FRAME_LEN more samples are accepted. `s_ready` then falls and `done` rises.
- R7: Only the first accepted trigger after a `start` counts. Later trigger edges do not change the number of samples taken.
- R8: In triggered mode with no accepted trigger, capture never stops and keeps overwriting the store circularly.
- R9: When capture stops, `stop_ptr` is the address the next sample would have used. Address (`stop_ptr`+k) mod 2*FRAME_LEN holds the k-th oldest stored sample.
- R10: With `done` high, `rd_en` with `rd_addr` gives the stored sample on `rd_data`, with `rd_valid` high, one cycle later. With `done` low, `rd_en` produces no `rd_valid`.
- R11: While `done` is high, `s_ready` stays low and samples offered on the stream do not change the stored contents.
- R12: `trig_in` may be asynchronous. It passes through two flip-flops and only its rising edge is used, so a trigger held high for several cycles counts once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that starts or restarts a capture |
| trig_mode | input | 1 | Mode sampled at start: 1 triggered, 0 untriggered |
| trig_in | input | 1 | Asynchronous trigger level |
| s_valid | input | 1 | Sample stream valid |
| s_ready | output | 1 | Sample stream ready |
| s_data | input | DATA_W | Sample value |
| rd_en | input | 1 | Read request |
| rd_addr | input | AW | Read address, AW = clog2(2*FRAME_LEN) |
| rd_valid | output | 1 | Read data valid, one cycle after the request |
| rd_data | output | DATA_W | Read data |
| done | output | 1 | Capture has stopped and the store is readable |
| stop_ptr | output | AW | Next write address at the moment capture stopped |

## Verification
The untriggered mode is run twice: once with back-to-back samples and once with an idle cycle between samples. This shows that writes follow accepted transfers and not clock cycles. The triggered mode gets three kinds of trigger pulse: a pulse during the first frame, which must not shorten the run; a held multi-cycle pulse after arming, which must start exactly one frame of post-trigger samples; and an extra pulse inside that post-trigger frame, which must not extend or restart it. A triggered run with no trigger at all must pass more than two frames without stopping, and is then aborted by a restart. Readback from `stop_ptr` upward, including a wrapped case, checks the chronological order. Writes offered after the stop must leave the contents unchanged.

// File: rtl/dfc_pkg.sv
package dfc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_WAIT,
    ST_POST,
    ST_DONE
  } cap_state_e;
endpackage

// File: rtl/dfc_trig_sync.sv
module dfc_trig_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_async,
  output logic trig_rise
);
  logic [2:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], trig_async};
  end

  // sh[1] is the second synchroniser stage, sh[2] its delayed copy
  assign trig_rise = sh[1] & ~sh[2];
endmodule

// File: rtl/dfc_ctrl.sv
module dfc_ctrl #(
  parameter int FRAME_LEN = 1024,
  parameter int AW        = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          trig_mode,
  input  logic          trig_rise,
  input  logic          s_valid,
  output logic          s_ready,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          done,
  output logic [AW-1:0] stop_ptr
);
  import dfc_pkg::*;

  localparam int DEPTH = 2 * FRAME_LEN;
  localparam int CW    = $clog2(FRAME_LEN + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(FRAME_LEN - 1);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  cap_state_e    st;
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] wr_next;
  logic [CW-1:0] cnt;
  logic          mode_q;
  logic          accept;

  assign s_ready = (st == ST_PRE) || (st == ST_WAIT) || (st == ST_POST);
  assign accept  = s_valid && s_ready;
  assign wr_next = (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
  assign wr_en   = accept;
  assign wr_addr = wr_ptr;
  assign done    = (st == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      wr_ptr   <= '0;
      cnt      <= '0;
      mode_q   <= 1'b0;
      stop_ptr <= '0;
    end else if (start) begin
      st     <= ST_PRE;
      wr_ptr <= '0;
      cnt    <= '0;
      mode_q <= trig_mode;
    end else begin
      if (accept) wr_ptr <= wr_next;
      unique case (st)
        ST_PRE: if (accept) begin
          if (cnt == LAST_CNT) begin
            cnt <= '0;
            st  <= ST_WAIT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WAIT: begin
          if (mode_q) begin
            if (trig_rise) begin
              st  <= ST_POST;
              cnt <= '0;
            end
          end else if (accept) begin
            if (cnt == LAST_CNT) begin
              st       <= ST_DONE;
              stop_ptr <= wr_next;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_POST: if (accept) begin
          if (cnt == LAST_CNT) begin
            st       <= ST_DONE;
            stop_ptr <= wr_next;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dfc_ram.sv
module dfc_ram #(
  parameter int DATA_W = 12,
  parameter int AW     = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_en;
  end
endmodule

// File: rtl/dual_frame_capture.sv
module dual_frame_capture #(
  parameter int DATA_W    = 12,
  parameter int FRAME_LEN = 1024,
  localparam int AW       = $clog2(2 * FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              trig_mode,
  input  logic              trig_in,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic [AW-1:0]     stop_ptr
);
  logic          trig_rise;
  logic          wr_en;
  logic [AW-1:0] wr_addr;

  dfc_trig_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_async (trig_in),
    .trig_rise  (trig_rise)
  );

  dfc_ctrl #(.FRAME_LEN(FRAME_LEN), .AW(AW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .trig_mode (trig_mode),
    .trig_rise (trig_rise),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .done      (done),
    .stop_ptr  (stop_ptr)
  );

  dfc_ram #(.DATA_W(DATA_W), .AW(AW)) u_ram (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (s_data),
    .rd_en    (rd_en && done),
    .rd_addr  (rd_addr),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/dfc_checker.sv
module dfc_checker #(
  parameter int FRAME_LEN = 1024,
  parameter int AW        = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          trig_mode,
  input logic          s_valid,
  input logic          s_ready,
  input logic          rd_en,
  input logic          rd_valid,
  input logic          done,
  input logic [AW-1:0] stop_ptr
);
  logic [31:0] n_acc;
  logic        mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_acc  <= '0;
      mode_q <= 1'b0;
    end else if (start) begin
      n_acc  <= '0;
      mode_q <= trig_mode;
    end else if (s_valid && s_ready) begin
      n_acc <= n_acc + 1;
    end
  end

  assert_start_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (s_ready && !done));

  assert_untrig_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && !mode_q) |-> (n_acc == 32'(2 * FRAME_LEN)));

  assert_stop_on_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(s_valid && s_ready));

  assert_stop_ptr_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> $stable(stop_ptr));

  assert_read_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en && done));

  assert_closed_when_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !s_ready);
endmodule

bind dual_frame_capture dfc_checker #(.FRAME_LEN(FRAME_LEN), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .trig_mode (trig_mode),
  .s_valid   (s_valid),
  .s_ready   (s_ready),
  .rd_en     (rd_en),
  .rd_valid  (rd_valid),
  .done      (done),
  .stop_ptr  (stop_ptr)
);

// File: tb/dual_frame_capture_tb.sv
module dual_frame_capture_tb;
  localparam int DATA_W = 12;
  localparam int F      = 16;
  localparam int DEPTH  = 2 * F;
  localparam int AW     = $clog2(DEPTH);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              trig_mode = 1'b0;
  logic              trig_in = 1'b0;
  logic              s_valid = 1'b0;
  logic              s_ready;
  logic [DATA_W-1:0] s_data = '0;
  logic              rd_en = 1'b0;
  logic [AW-1:0]     rd_addr = '0;
  logic              rd_valid;
  logic [DATA_W-1:0] rd_data;
  logic              done;
  logic [AW-1:0]     stop_ptr;

  int checks = 0;
  int errors = 0;
  int idx = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dual_frame_capture #(.DATA_W(DATA_W), .FRAME_LEN(F)) u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_start(input bit m);
    start = 1'b1; trig_mode = m;
    @(negedge clk);
    start = 1'b0;
    idx = 0;
    chk("R2 ready after start", int'(s_ready), 1);
    chk("R2 done cleared", int'(done), 0);
  endtask

  task automatic feed(input int max_acc, input int gap, output int got);
    bit acc;
    got = 0;
    while (got < max_acc) begin
      if (!s_ready) break;
      s_valid = 1'b1; s_data = DATA_W'(idx);
      acc = s_ready;
      @(negedge clk);
      if (acc) begin idx++; got++; end
      s_valid = 1'b0;
      repeat (gap) @(negedge clk);
    end
    s_valid = 1'b0;
  endtask

  task automatic pulse_trig();
    trig_in = 1'b1;
    repeat (3) @(negedge clk);
    trig_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic read_back(input int first_val);
    for (int k = 0; k < DEPTH; k++) begin
      rd_en = 1'b1; rd_addr = AW'((int'(stop_ptr) + k) % DEPTH);
      @(negedge clk);
      rd_en = 1'b0;
      chk("R10 rd_valid", int'(rd_valid), 1);
      chk("R9 chronological data", int'(rd_data), first_val + k);
    end
  endtask

  task automatic t_reset();
    chk("R1 done", int'(done), 0);
    chk("R1 s_ready", int'(s_ready), 0);
    chk("R1 rd_valid", int'(rd_valid), 0);
  endtask

  task automatic t_untrig(input int gap);
    int got;
    do_start(1'b0);
    feed(1000, gap, got);
    chk("R4 accepted count", got, DEPTH);
    chk("R4 done", int'(done), 1);
    chk("R4 stop_ptr", int'(stop_ptr), 0);
    // R11: offered samples after the stop are refused
    s_valid = 1'b1; s_data = 12'hABC;
    repeat (5) @(negedge clk);
    chk("R11 ready low while done", int'(s_ready), 0);
    s_valid = 1'b0;
    read_back(0);  // R3 addresses follow accept order
  endtask

  task automatic t_trig();
    int got;
    int post;
    do_start(1'b1);
    feed(5, 0, got);
    pulse_trig();  // R5 early trigger must be ignored
    feed(F - 5, 0, got);
    chk("R5 rest of first frame accepted", got, F - 5);
    feed(7, 0, got);
    chk("R5 still capturing after first frame", got, 7);
    chk("R5 ready before real trigger", int'(s_ready), 1);
    pulse_trig();  // R12 held three cycles, counts once
    feed(8, 0, got);
    post = got;
    pulse_trig();  // R7 second trigger ignored
    feed(1000, 0, got);
    post += got;
    chk("R6 post-trigger count", post, F);
    chk("R6 done", int'(done), 1);
    chk("R6 ready low", int'(s_ready), 0);
    chk("R9 stop_ptr", int'(stop_ptr), (F + 7 + F) % DEPTH);
    read_back(7);
  endtask

  task automatic t_no_trig_restart();
    int got;
    do_start(1'b1);
    feed(3 * F, 0, got);
    chk("R8 accepted past two frames", got, 3 * F);
    chk("R8 no stop", int'(done), 0);
    chk("R8 ready", int'(s_ready), 1);
    rd_en = 1'b1; rd_addr = '0;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R10 no read while capturing", int'(rd_valid), 0);
    t_untrig(1);  // R2 restart mid-capture, gapped stream
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_untrig(0);
    t_trig();
    t_no_trig_restart();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule